// File: doc/BRIEF.md
# CAN Controller Register and Interrupt Unit

This block is the byte-wide host register file of a CAN controller in its extended register mode. A host CPU writes and reads it over a simple address/data bus. The bus has a single-cycle write strobe, a read strobe and a combinational read path. The block holds these registers:

- the mode register, which selects reset or operating mode and single or dual acceptance filtering;
- the interrupt-enable register;
- eight acceptance code/mask bytes, which go to a neighbouring filter;
- a thirteen-byte transmit buffer.

Command writes start a transmission, release a received message or clear a data overrun. A transmission is handed to an external frame engine as the flattened buffer plus a one-cycle send pulse. Release and overrun-clear commands are passed on to an external receive buffer as one-cycle pulses. That receive buffer reports three things back: its pending message count, a pulse for each stored message and a pulse for each overrun. In operating mode it also supplies the byte at the offset being read in the shared register window.

The block keeps the status byte and the interrupt flag byte. It drives one registered, level-sensitive interrupt line, which is the OR of the enabled interrupt flags. Reading the interrupt register clears its flags. The receive flag is set again at once while messages remain unread.

Top module: `can_reg_irq_unit`

## Requirements
- R1: After reset the mode register reads 0x01, the status register (address 2) reads 0x3C, the interrupt register (address 3) reads 0x00 and `irq` is low.
- R2: A write to address 0 stores only the low 5 bits of the data. Mode bit 0 = 1 means reset mode, and mode bit 3 drives `single_filter`.
- R3: Address 1 is the command register and always reads 0x00. In the written data, bit 0 requests a transmission, bit 2 releases a received message and bit 3 clears the data overrun.
- R4: A transmit request pulses `tx_send` high for the one cycle after the write edge. `tx_frame` then holds buffer byte i at bits [8i+7:8i]. At the same edge status bits 2 and 3 are set, status bit 5 is cleared and interrupt bit 1 is set.
- R5: Any write to address 16 sets status bit 5. In operating mode, writes to addresses 16..28 store into transmit buffer byte (address-16). In reset mode they leave the transmit buffer unchanged.
- R6: In reset mode, addresses 16..23 read and write acceptance byte (address-16), which appears on `acc_bytes` at bits [8i+7:8i], and addresses 24..28 read 0x00. In operating mode, acceptance writes are ignored and reads of 16..28 return `rx_rd_byte`, with `rx_rd_offset` = address-16.
- R7: Status bit 0 is 1 whenever `rx_count` is non-zero. An `rx_stored` pulse sets interrupt bit 0. An `rx_stored` or `rx_overrun` pulse clears status bit 4 (receiving).
- R8: A read of address 3 returns the interrupt byte and then clears it. If `rx_count` is non-zero at that read, bit 0 stays set.
- R9: `irq` is a register that, at each edge, takes the OR of interrupt bits 0, 1 and 3, each ANDed with the same bit of the enable register (address 4). The interrupt bits used are their values after that edge; the enable value is the one held before it.
- R10: A release command pulses `rx_release` for one cycle only if `rx_count` is non-zero; with a count of zero it has no effect. When `rx_count` is 1 the release also clears interrupt bit 0.
- R11: An `rx_overrun` pulse sets status bit 1 and interrupt bit 3. The clear-overrun command clears both bits and pulses `rx_ovr_clr` for one cycle.
- R12: The enable register at address 4 reads back what was written. Addresses 5..15 read 0x00, and addresses 29..31 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe (side effects of reading) |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Level interrupt line, registered |
| single_filter | output | 1 | Single acceptance filter mode selected |
| acc_bytes | output | 8*ACC_BYTES | Acceptance code/mask bytes, byte i at [8i+7:8i] |
| tx_frame | output | 8*TXB_BYTES | Transmit buffer, byte i at [8i+7:8i] |
| tx_send | output | 1 | One-cycle transmit pulse |
| rx_count | input | CNT_W | Pending message count from the receive buffer |
| rx_stored | input | 1 | Pulse: a message was stored |
| rx_overrun | input | 1 | Pulse: a message was lost to overrun |
| rx_release | output | 1 | One-cycle release pulse to the receive buffer |
| rx_ovr_clr | output | 1 | One-cycle overrun-clear pulse |
| rx_rd_offset | output | OFF_W | Byte offset of the current window read |
| rx_rd_byte | input | 8 | Receive buffer byte at that offset |

## Verification
The assertions check the following on every cycle:
- the status and flag effects of a transmit request;
- that the receive flag is present after a stored message;
- that a read of the interrupt register with nothing pending leaves the flags and the line low;
- that the release pulse is never issued with an empty buffer;
- that the overrun clear takes effect;
- that the acceptance bytes hold still outside reset mode;
- that `tx_send` always follows a transmit command.

The bench scenarios show the rest:
- the exact byte values in the register window in each mode;
- the re-arming of the receive flag across repeated interrupt reads;
- the last-message release clearing the flag;
- the enable masking and its one-cycle delay;
- the fixed read values of the reserved and unmapped addresses.

// File: rtl/can_ru_pkg.sv
package can_ru_pkg;
   // register addresses below the shared window
   localparam int unsigned A_MODE   = 0;
   localparam int unsigned A_CMD    = 1;
   localparam int unsigned A_STAT   = 2;
   localparam int unsigned A_INTR   = 3;
   localparam int unsigned A_IEN    = 4;
   localparam int unsigned A_RSV_LO = 5;
   localparam int unsigned A_RSV_HI = 15;

   // mode bits
   localparam int unsigned MODE_RST = 0;
   localparam int unsigned MODE_SGL = 3;
   localparam logic [4:0]  MODE_RESET_VAL = 5'h01;

   // command bits
   localparam int unsigned CMD_TX  = 0;
   localparam int unsigned CMD_REL = 2;
   localparam int unsigned CMD_OVC = 3;

   // interrupt bits
   localparam int unsigned IR_RX = 0;
   localparam int unsigned IR_TX = 1;
   localparam int unsigned IR_OV = 3;
endpackage

// File: rtl/can_ru_regs.sv
module can_ru_regs
   import can_ru_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned WIN_BASE  = 16,
   parameter int unsigned TXB_BYTES = 13,
   parameter int unsigned ACC_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             wr_data,
   output logic [4:0]             mode_q,
   output logic [7:0]             ien_q,
   output logic [ACC_BYTES*8-1:0] acc_flat,
   output logic [TXB_BYTES*8-1:0] txb_flat
);
   logic       rst_mode;
   logic [7:0] acc_q [ACC_BYTES];
   logic [7:0] txb_q [TXB_BYTES];

   assign rst_mode = mode_q[MODE_RST];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET_VAL;
         ien_q  <= 8'h00;
      end else if (wr_en) begin
         if (addr == ADDR_W'(A_MODE)) mode_q <= wr_data[4:0];
         if (addr == ADDR_W'(A_IEN))  ien_q  <= wr_data;
      end
   end

   // acceptance bytes: writable only while in reset mode
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(ACC_BYTES); i++) acc_q[i] <= 8'h00;
      end else if (wr_en && rst_mode) begin
         for (int i = 0; i < int'(ACC_BYTES); i++)
            if (addr == ADDR_W'(WIN_BASE + i)) acc_q[i] <= wr_data;
      end
   end

   // transmit buffer: writable only while operating
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(TXB_BYTES); i++) txb_q[i] <= 8'h00;
      end else if (wr_en && !rst_mode) begin
         for (int i = 0; i < int'(TXB_BYTES); i++)
            if (addr == ADDR_W'(WIN_BASE + i)) txb_q[i] <= wr_data;
      end
   end

   for (genvar g = 0; g < int'(ACC_BYTES); g++) begin : g_acc_flat
      assign acc_flat[8*g +: 8] = acc_q[g];
   end
   for (genvar g = 0; g < int'(TXB_BYTES); g++) begin : g_txb_flat
      assign txb_flat[8*g +: 8] = txb_q[g];
   end

   // R6
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_mode |=> $stable(acc_flat));
endmodule

// File: rtl/can_ru_flags.sv
module can_ru_flags
   import can_ru_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_req,
   input  logic             rel_req,
   input  logic             ovc_req,
   input  logic             win0_wr,
   input  logic             ir_rd,
   input  logic             ie_rx,
   input  logic             ie_tx,
   input  logic             ie_ov,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_stored,
   input  logic             rx_overrun,
   output logic [7:0]       status_byte,
   output logic [7:0]       intr_byte,
   output logic             irq,
   output logic             tx_send,
   output logic             rx_release,
   output logic             rx_ovr_clr
);
   logic has_pending;
   logic ovr_q, txrel_q, txdone_q, rcv_q, txing_q;
   logic ir_rx_q, ir_tx_q, ir_ov_q;
   logic ir_rx_d, ir_tx_d, ir_ov_d;

   assign has_pending = |rx_count;

   // clearing sources first, setting events last so they win
   always_comb begin
      ir_rx_d = ir_rx_q;
      ir_tx_d = ir_tx_q;
      ir_ov_d = ir_ov_q;
      if (ir_rd) begin
         ir_rx_d = has_pending;
         ir_tx_d = 1'b0;
         ir_ov_d = 1'b0;
      end
      if (rel_req && rx_count == CNT_W'(1)) ir_rx_d = 1'b0;
      if (ovc_req)    ir_ov_d = 1'b0;
      if (rx_stored)  ir_rx_d = 1'b1;
      if (tx_req)     ir_tx_d = 1'b1;
      if (rx_overrun) ir_ov_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_rx_q <= 1'b0;
         ir_tx_q <= 1'b0;
         ir_ov_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         ir_rx_q <= ir_rx_d;
         ir_tx_q <= ir_tx_d;
         ir_ov_q <= ir_ov_d;
         irq     <= (ir_rx_d & ie_rx) | (ir_tx_d & ie_tx) | (ir_ov_d & ie_ov);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q    <= 1'b0;
         txrel_q  <= 1'b1;
         txdone_q <= 1'b1;
         rcv_q    <= 1'b1;
         txing_q  <= 1'b1;
      end else begin
         if (win0_wr) txing_q <= 1'b1;
         if (tx_req) begin
            txrel_q  <= 1'b1;
            txdone_q <= 1'b1;
            txing_q  <= 1'b0;
         end
         if (rx_stored || rx_overrun) rcv_q <= 1'b0;
         if (ovc_req)    ovr_q <= 1'b0;
         if (rx_overrun) ovr_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_send    <= 1'b0;
         rx_release <= 1'b0;
         rx_ovr_clr <= 1'b0;
      end else begin
         tx_send    <= tx_req;
         rx_release <= rel_req && has_pending;
         rx_ovr_clr <= ovc_req;
      end
   end

   assign status_byte = {2'b00, txing_q, rcv_q, txdone_q, txrel_q, ovr_q, has_pending};
   assign intr_byte   = {4'b0000, ir_ov_q, 1'b0, ir_tx_q, ir_rx_q};

   // R4
   tx_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> (status_byte[3:2] == 2'b11) && !status_byte[5] && intr_byte[IR_TX]);
   // R7
   rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stored |=> intr_byte[IR_RX] && !status_byte[4]);
   // R8
   ir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_rd && !has_pending && !rx_stored && !rx_overrun && !tx_req)
      |=> (intr_byte == 8'h00) && !irq);
   // R10
   release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_release |-> $past(rx_count) != '0);
   // R11
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovc_req && !rx_overrun) |=> !status_byte[1] && !intr_byte[IR_OV] && rx_ovr_clr);
endmodule

// File: rtl/can_ru_rdmux.sv
module can_ru_rdmux
   import can_ru_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned WIN_BASE  = 16,
   parameter int unsigned TXB_BYTES = 13,
   parameter int unsigned ACC_BYTES = 8,
   parameter int unsigned OFF_W     = 4
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [4:0]             mode_q,
   input  logic [7:0]             ien_q,
   input  logic [7:0]             status_byte,
   input  logic [7:0]             intr_byte,
   input  logic [ACC_BYTES*8-1:0] acc_flat,
   input  logic [7:0]             rx_rd_byte,
   output logic [OFF_W-1:0]       rx_rd_offset,
   output logic [7:0]             rd_data
);
   int unsigned a_i;
   int unsigned rel;

   assign a_i          = 32'(addr);
   assign rel          = a_i - WIN_BASE;
   assign rx_rd_offset = OFF_W'(rel);

   always_comb begin
      rd_data = 8'hFF;
      if (a_i == A_MODE)                          rd_data = {3'b000, mode_q};
      else if (a_i == A_CMD)                      rd_data = 8'h00;
      else if (a_i == A_STAT)                     rd_data = status_byte;
      else if (a_i == A_INTR)                     rd_data = intr_byte;
      else if (a_i == A_IEN)                      rd_data = ien_q;
      else if (a_i >= A_RSV_LO && a_i <= A_RSV_HI) rd_data = 8'h00;
      else if (a_i >= WIN_BASE && a_i < WIN_BASE + TXB_BYTES) begin
         if (mode_q[MODE_RST]) begin
            if (rel < ACC_BYTES) rd_data = acc_flat[8*rel +: 8];
            else                 rd_data = 8'h00;
         end else begin
            rd_data = rx_rd_byte;
         end
      end
   end
endmodule

// File: rtl/can_reg_irq_unit.sv
module can_reg_irq_unit
   import can_ru_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned WIN_BASE  = 16,
   parameter int unsigned TXB_BYTES = 13,
   parameter int unsigned ACC_BYTES = 8,
   parameter int unsigned CNT_W     = 7,
   localparam int unsigned OFF_W    = $clog2(TXB_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             wr_data,
   output logic [7:0]             rd_data,
   output logic                   irq,
   output logic                   single_filter,
   output logic [ACC_BYTES*8-1:0] acc_bytes,
   output logic [TXB_BYTES*8-1:0] tx_frame,
   output logic                   tx_send,
   input  logic [CNT_W-1:0]       rx_count,
   input  logic                   rx_stored,
   input  logic                   rx_overrun,
   output logic                   rx_release,
   output logic                   rx_ovr_clr,
   output logic [OFF_W-1:0]       rx_rd_offset,
   input  logic [7:0]             rx_rd_byte
);
   if (WIN_BASE + TXB_BYTES > (1 << ADDR_W)) begin : g_chk_win
      $error("register window does not fit the address space");
   end
   if (ACC_BYTES > TXB_BYTES) begin : g_chk_acc
      $error("acceptance bytes exceed window size");
   end
   if (WIN_BASE <= A_RSV_HI) begin : g_chk_base
      $error("window overlaps fixed registers");
   end

   logic [4:0] mode_q;
   logic [7:0] ien_q;
   logic [7:0] status_byte;
   logic [7:0] intr_byte;
   logic       cmd_wr, tx_req, rel_req, ovc_req, win0_wr, ir_rd;

   assign cmd_wr  = wr_en && (addr == ADDR_W'(A_CMD));
   assign tx_req  = cmd_wr && wr_data[CMD_TX];
   assign rel_req = cmd_wr && wr_data[CMD_REL];
   assign ovc_req = cmd_wr && wr_data[CMD_OVC];
   assign win0_wr = wr_en && (addr == ADDR_W'(WIN_BASE));
   assign ir_rd   = rd_en && (addr == ADDR_W'(A_INTR));

   assign single_filter = mode_q[MODE_SGL];

   can_ru_regs #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
      .TXB_BYTES(TXB_BYTES), .ACC_BYTES(ACC_BYTES)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .mode_q(mode_q), .ien_q(ien_q), .acc_flat(acc_bytes), .txb_flat(tx_frame)
   );

   can_ru_flags #(.CNT_W(CNT_W)) i_flags (
      .clk(clk), .rst_n(rst_n),
      .tx_req(tx_req), .rel_req(rel_req), .ovc_req(ovc_req),
      .win0_wr(win0_wr), .ir_rd(ir_rd),
      .ie_rx(ien_q[IR_RX]), .ie_tx(ien_q[IR_TX]), .ie_ov(ien_q[IR_OV]),
      .rx_count(rx_count), .rx_stored(rx_stored), .rx_overrun(rx_overrun),
      .status_byte(status_byte), .intr_byte(intr_byte), .irq(irq),
      .tx_send(tx_send), .rx_release(rx_release), .rx_ovr_clr(rx_ovr_clr)
   );

   can_ru_rdmux #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .TXB_BYTES(TXB_BYTES),
      .ACC_BYTES(ACC_BYTES), .OFF_W(OFF_W)
   ) i_rdmux (
      .addr(addr), .mode_q(mode_q), .ien_q(ien_q),
      .status_byte(status_byte), .intr_byte(intr_byte),
      .acc_flat(acc_bytes), .rx_rd_byte(rx_rd_byte),
      .rx_rd_offset(rx_rd_offset), .rd_data(rd_data)
   );

   // R4
   tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_send |-> $past(wr_en && addr == ADDR_W'(A_CMD) && wr_data[CMD_TX]));
endmodule

// File: tb/test_can_reg_irq_unit.sv
module test_can_reg_irq_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [4:0]   addr = '0;
   logic [7:0]   wr_data = '0;
   logic [7:0]   rd_data;
   logic         irq;
   logic         single_filter;
   logic [63:0]  acc_bytes;
   logic [103:0] tx_frame;
   logic         tx_send;
   logic [6:0]   rx_count = '0;
   logic         rx_stored = 1'b0;
   logic         rx_overrun = 1'b0;
   logic         rx_release;
   logic         rx_ovr_clr;
   logic [3:0]   rx_rd_offset;
   logic [7:0]   rx_rd_byte;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [4:0] a;
      logic [7:0] exp;
      string      req;
   } rd_item_t;
   rd_item_t exp_q[$];

   always #2 clk = ~clk;

   // receive buffer model: byte at offset k reads 0x40|k
   assign rx_rd_byte = {4'h4, rx_rd_offset};

   can_reg_irq_unit i_can_reg_irq_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
      .single_filter(single_filter), .acc_bytes(acc_bytes),
      .tx_frame(tx_frame), .tx_send(tx_send), .rx_count(rx_count),
      .rx_stored(rx_stored), .rx_overrun(rx_overrun),
      .rx_release(rx_release), .rx_ovr_clr(rx_ovr_clr),
      .rx_rd_offset(rx_rd_offset), .rx_rd_byte(rx_rd_byte)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected read values and compares mid-cycle
   always @(negedge clk) begin
      rd_item_t it;
      if (rd_en && exp_q.size() > 0) begin
         it = exp_q.pop_front();
         chk($sformatf("%s read addr %0d", it.req, it.a), 32'(rd_data), 32'(it.exp));
      end
   end

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [7:0] e, input string req);
      rd_item_t it;
      @(posedge clk); #1;
      rd_en = 1'b1; addr = a;
      it.a = a; it.exp = e; it.req = req;
      exp_q.push_back(it);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk); #1;
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      if (!done) begin
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1
      chk("R1 irq", 32'(irq), 0);
      rd(0, 8'h01, "R1");
      rd(2, 8'h3C, "R1");
      rd(3, 8'h00, "R1");

      // R12 enable register and fixed reads
      wr(4, 8'h0B);
      rd(4, 8'h0B, "R12");
      rd(5, 8'h00, "R12");
      rd(9, 8'h00, "R12");
      rd(15, 8'h00, "R12");
      rd(29, 8'hFF, "R12");
      rd(31, 8'hFF, "R12");
      // R3
      rd(1, 8'h00, "R3");

      // R4 transmit request in reset mode
      wr(1, 8'h01);
      chk("R4 tx_send", 32'(tx_send), 1);
      chk("R9 irq after tx", 32'(irq), 1);
      idle();
      chk("R4 tx_send one cycle", 32'(tx_send), 0);
      rd(2, 8'h1C, "R4");
      rd(3, 8'h02, "R8");
      chk("R8 irq low after read", 32'(irq), 0);
      rd(3, 8'h00, "R8");

      // R2 mode write keeps low 5 bits
      wr(0, 8'hE9);
      rd(0, 8'h09, "R2");
      chk("R2 single_filter", 32'(single_filter), 1);

      // R5/R6 reset-mode window
      wr(16, 8'h11);
      rd(2, 8'h3C, "R5");
      for (int i = 0; i < 8; i++) wr(5'(16 + i), 8'(8'hA0 + i));
      for (int i = 0; i < 8; i++) rd(5'(16 + i), 8'(8'hA0 + i), "R6");
      rd(24, 8'h00, "R6");
      rd(28, 8'h00, "R6");
      chk("R6 acc_bytes", acc_bytes[31:0], 32'hA3A2A1A0);
      chk("R6 acc_bytes hi", acc_bytes[63:32], 32'hA7A6A5A4);
      chk("R5 tx buffer untouched in reset mode", 32'(tx_frame[7:0]), 0);

      // operating mode
      wr(0, 8'h00);
      rd(0, 8'h00, "R2");
      chk("R2 single_filter off", 32'(single_filter), 0);
      for (int i = 0; i < 13; i++) wr(5'(16 + i), 8'(8'h50 + i));
      chk("R6 acc ignored in operating mode", acc_bytes[31:0], 32'hA3A2A1A0);
      rd(20, 8'h44, "R6");
      rd(28, 8'h4C, "R6");
      wr(1, 8'h01);
      chk("R4 tx_send op", 32'(tx_send), 1);
      for (int i = 0; i < 13; i++)
         chk("R4 R5 tx_frame byte", 32'(tx_frame[8*i +: 8]), 32'(8'h50 + i));
      rd(2, 8'h1C, "R4");
      rd(3, 8'h02, "R8");

      // R7/R8 receive path
      @(posedge clk); #1;
      rx_count = 7'd2; rx_stored = 1'b1;
      @(posedge clk); #1;
      rx_stored = 1'b0;
      chk("R7 irq on stored", 32'(irq), 1);
      rd(2, 8'h0D, "R7");
      rd(3, 8'h01, "R8");
      chk("R8 irq stays with pending", 32'(irq), 1);
      rd(3, 8'h01, "R8");

      // R10 release
      wr(1, 8'h04);
      chk("R10 release pulse", 32'(rx_release), 1);
      rx_count = 7'd1;
      rd(3, 8'h01, "R10");
      wr(1, 8'h04);
      chk("R10 release last", 32'(rx_release), 1);
      chk("R10 irq low after last release", 32'(irq), 0);
      rx_count = 7'd0;
      rd(3, 8'h00, "R10");
      rd(2, 8'h0C, "R7");
      wr(1, 8'h04);
      chk("R10 release ignored when empty", 32'(rx_release), 0);

      // R11 overrun
      @(posedge clk); #1;
      rx_overrun = 1'b1;
      @(posedge clk); #1;
      rx_overrun = 1'b0;
      chk("R11 irq on overrun", 32'(irq), 1);
      rd(2, 8'h0E, "R11");
      wr(1, 8'h08);
      chk("R11 ovr_clr pulse", 32'(rx_ovr_clr), 1);
      chk("R11 irq low after clear", 32'(irq), 0);
      rd(2, 8'h0C, "R11");
      rd(3, 8'h00, "R11");

      // R9 masking
      wr(4, 8'h00);
      @(posedge clk); #1;
      rx_count = 7'd1; rx_stored = 1'b1;
      @(posedge clk); #1;
      rx_stored = 1'b0;
      chk("R9 masked irq", 32'(irq), 0);
      wr(4, 8'h01);
      idle();
      chk("R9 irq after enable", 32'(irq), 1);
      rd(3, 8'h01, "R9");

      idle();
      chk("queue drained", 32'(exp_q.size()), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule